// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a cache and serves that cache's misses from a set of small FIFO stream buffers. The buffers hold blocks fetched ahead of demand. Prefetched blocks stay in the buffers and reach the cache only when a later miss asks for them, so speculative fetches never evict useful cache lines. The cache presents each miss as a block address with a one-cycle strobe. The block then answers with either a hit carrying the line data or a non-hit. After a non-hit the cache issues its own demand fetch for the block.

A miss that matches no buffer head claims the least recently used buffer. That buffer is cleared and its prefetch pointer is set to the block after the missing one. Each active buffer then requests the next sequential blocks from memory through a separate request port, until the buffer is full. A miss that matches the head of a buffer takes that head. The buffer then shifts by one, which frees a slot for the next sequential prefetch. Prefetch traffic gives way whenever the cache reports a demand fetch in flight. At most one prefetch is outstanding at a time, and responses return in request order.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, `resp_valid_o`, `pf_req_valid_o` and `lookup_busy_o` are all 0, and no request is issued until a miss has allocated a buffer.
- R2: A miss accepted while idle that matches no buffer head produces `resp_valid_o`=1 with `resp_hit_o`=0 in the next cycle. The chosen buffer then prefetches starting at the miss address plus one.
- R3: A buffer requests consecutive block addresses (base, base+1, ...). It stops requesting once it holds DEPTH entries, counting entries still waiting for data.
- R4: While `demand_busy_i` is 1, `pf_req_valid_o` is 0.
- R5: A miss that equals a buffer head whose data has arrived produces `resp_valid_o`=1 with `resp_hit_o`=1 and that block's data in the next cycle. It frees one slot, so the buffer's next request is the following sequential address.
- R6: A miss that equals a buffer head whose data is still pending raises `lookup_busy_o` and withholds the response. The response appears (hit, correct data) one cycle after the cycle in which `pf_rsp_valid_i` delivers that block, and `lookup_busy_o` falls in that same cycle.
- R7: Only buffer heads are compared. A miss equal to a later entry of a buffer gets a non-hit response and leaves that buffer's head in place.
- R8: On a non-hit, the buffer replaced is the one least recently allocated or hit. Buffers used more recently keep their contents.
- R9: After a request is acknowledged, `pf_req_valid_o` stays 0 until the matching `pf_rsp_valid_i`.
- R10: If the buffer that issued a request is reallocated before the data returns, that data is dropped. A later miss on its address does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid_i | input | 1 | Cache miss strobe, taken only while `lookup_busy_o` is 0 |
| miss_addr_i | input | ADDR_W | Block address of the miss |
| lookup_busy_o | output | 1 | A head match is waiting for its data |
| resp_valid_o | output | 1 | Lookup result valid (one cycle) |
| resp_hit_o | output | 1 | 1: block supplied from a buffer; 0: cache must fetch |
| resp_data_o | output | DATA_W | Block data on a hit |
| demand_busy_i | input | 1 | Cache demand fetch in flight; blocks prefetch requests |
| pf_req_valid_o | output | 1 | Prefetch request |
| pf_req_addr_o | output | ADDR_W | Prefetch block address |
| pf_req_ack_i | input | 1 | Memory accepts the request this cycle |
| pf_rsp_valid_i | input | 1 | Prefetch data returning |
| pf_rsp_data_i | input | DATA_W | Returned block data |

## Verification
A wrong head pointer or a stale tag shows at the ports on the next miss to that stream: a hit turns into a non-hit, or the hit carries the data of another block, one cycle after the strobe. A corrupted fill count or prefetch pointer shows within a few request cycles, as a gap, a repeat or an overrun in the sequence of request addresses. A faulty replacement order or a lost flush stays hidden until a later miss targets the buffer that should have survived or been cleared. The bench therefore follows every eviction with misses that probe both the victim and the buffers that should have survived.

// File: rtl/pf_pkg.sv
package pf_pkg;
   typedef enum logic [0:0] {
      LK_IDLE  = 1'b0,
      LK_STALL = 1'b1
   } lk_state_e;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pf_lru.sv
module pf_lru #(
   parameter int unsigned NUM = 4,
   localparam int unsigned IW = pf_pkg::id_width(NUM)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_i,
   input  logic [IW-1:0] touch_id_i,
   output logic [IW-1:0] victim_o
);
   logic [IW-1:0] age_q [NUM];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) age_q[i] <= IW'(i);
      end else if (touch_i) begin
         for (int i = 0; i < NUM; i++) begin
            if (IW'(i) == touch_id_i)                age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_id_i])   age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_o = '0;
      for (int i = 0; i < NUM; i++)
         if (age_q[i] == IW'(NUM - 1)) victim_o = IW'(i);
   end
endmodule

// File: rtl/pf_stream_buf.sv
module pf_stream_buf #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              pop_i,
   input  logic              push_i,
   input  logic              fill_i,
   input  logic [ADDR_W-1:0] fill_addr_i,
   input  logic [DATA_W-1:0] fill_data_i,
   output logic              head_vld_o,
   output logic              head_rdy_o,
   output logic [ADDR_W-1:0] head_addr_o,
   output logic [DATA_W-1:0] head_data_o,
   output logic              can_issue_o,
   output logic [ADDR_W-1:0] next_addr_o
);
   logic              act_q, act_d;
   logic [CW-1:0]     cnt_q, cnt_d;
   logic [ADDR_W-1:0] nxt_q, nxt_d;
   logic              rdy_q [DEPTH];
   logic              rdy_d [DEPTH];
   logic [ADDR_W-1:0] tag_q [DEPTH];
   logic [ADDR_W-1:0] tag_d [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [DATA_W-1:0] dat_d [DEPTH];

   always_comb begin
      act_d = act_q;
      cnt_d = cnt_q;
      nxt_d = nxt_q;
      rdy_d = rdy_q;
      tag_d = tag_q;
      dat_d = dat_q;
      // data return lands on the pending entry carrying the same tag
      if (fill_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt_q && !rdy_q[i] && tag_q[i] == fill_addr_i) begin
               rdy_d[i] = 1'b1;
               dat_d[i] = fill_data_i;
            end
         end
      end
      if (pop_i) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            rdy_d[i] = rdy_d[i+1];
            tag_d[i] = tag_d[i+1];
            dat_d[i] = dat_d[i+1];
         end
         rdy_d[DEPTH-1] = 1'b0;
         cnt_d = cnt_d - 1'b1;
      end
      if (push_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == cnt_d) begin
               rdy_d[i] = 1'b0;
               tag_d[i] = nxt_q;
            end
         end
         cnt_d = cnt_d + 1'b1;
         nxt_d = nxt_q + 1'b1;
      end
      if (flush_i) begin
         act_d = 1'b1;
         cnt_d = '0;
         nxt_d = base_i;
         for (int i = 0; i < DEPTH; i++) rdy_d[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         nxt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            rdy_q[i] <= 1'b0;
            tag_q[i] <= '0;
            dat_q[i] <= '0;
         end
      end else begin
         act_q <= act_d;
         cnt_q <= cnt_d;
         nxt_q <= nxt_d;
         rdy_q <= rdy_d;
         tag_q <= tag_d;
         dat_q <= dat_d;
      end
   end

   assign head_vld_o  = (cnt_q != '0);
   assign head_rdy_o  = (cnt_q != '0) && rdy_q[0];
   assign head_addr_o = tag_q[0];
   assign head_data_o = dat_q[0];
   assign can_issue_o = act_q && (cnt_q < CW'(DEPTH));
   assign next_addr_o = nxt_q;
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_STREAMS = 4,
   parameter int unsigned DEPTH       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid_i,
   input  logic [ADDR_W-1:0] miss_addr_i,
   output logic              lookup_busy_o,
   output logic              resp_valid_o,
   output logic              resp_hit_o,
   output logic [DATA_W-1:0] resp_data_o,
   input  logic              demand_busy_i,
   output logic              pf_req_valid_o,
   output logic [ADDR_W-1:0] pf_req_addr_o,
   input  logic              pf_req_ack_i,
   input  logic              pf_rsp_valid_i,
   input  logic [DATA_W-1:0] pf_rsp_data_i
);
   import pf_pkg::*;
   localparam int unsigned IW = id_width(NUM_STREAMS);

   generate
      if (!(NUM_STREAMS == 1 || NUM_STREAMS == 4 || NUM_STREAMS == 8)) begin : g_bad_streams
         initial $error("NUM_STREAMS must be 1, 4 or 8");
      end
      if (DEPTH < 2) begin : g_bad_depth
         initial $error("DEPTH must be at least 2");
      end
   endgenerate

   logic [NUM_STREAMS-1:0] head_vld, head_rdy, can_issue, flush, pop, push, fill;
   logic [ADDR_W-1:0]      head_addr [NUM_STREAMS];
   logic [ADDR_W-1:0]      next_addr [NUM_STREAMS];
   logic [DATA_W-1:0]      head_data [NUM_STREAMS];
   logic [ADDR_W-1:0]      base;
   logic                   outst_q;
   logic [IW-1:0]          outst_id_q;
   logic [ADDR_W-1:0]      outst_addr_q;

   assign base = miss_addr_i + ADDR_W'(1);

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_buf
      assign fill[g] = pf_rsp_valid_i && outst_q && (outst_id_q == IW'(g));
      pf_stream_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
         .clk        (clk),
         .rst_n      (rst_n),
         .flush_i    (flush[g]),
         .base_i     (base),
         .pop_i      (pop[g]),
         .push_i     (push[g]),
         .fill_i     (fill[g]),
         .fill_addr_i(outst_addr_q),
         .fill_data_i(pf_rsp_data_i),
         .head_vld_o (head_vld[g]),
         .head_rdy_o (head_rdy[g]),
         .head_addr_o(head_addr[g]),
         .head_data_o(head_data[g]),
         .can_issue_o(can_issue[g]),
         .next_addr_o(next_addr[g])
      );
   end

   // lowest-numbered stream wins both the head match and the issue slot
   logic          any_hit, any_iss;
   logic [IW-1:0] hit_id, iss_id;
   always_comb begin
      any_hit = 1'b0;
      hit_id  = '0;
      any_iss = 1'b0;
      iss_id  = '0;
      for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
         if (head_vld[s] && head_addr[s] == miss_addr_i) begin
            any_hit = 1'b1;
            hit_id  = IW'(s);
         end
         if (can_issue[s]) begin
            any_iss = 1'b1;
            iss_id  = IW'(s);
         end
      end
   end

   // lookup control
   lk_state_e     st_q, st_d;
   logic [IW-1:0] sel_q, sel_d;
   logic          touch;
   logic [IW-1:0] touch_id, victim;
   logic          rv_d, rh_d;
   logic [DATA_W-1:0] rd_d;

   pf_lru #(.NUM(NUM_STREAMS)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_i   (touch),
      .touch_id_i(touch_id),
      .victim_o  (victim)
   );

   always_comb begin
      st_d     = st_q;
      sel_d    = sel_q;
      pop      = '0;
      flush    = '0;
      touch    = 1'b0;
      touch_id = '0;
      rv_d     = 1'b0;
      rh_d     = 1'b0;
      rd_d     = '0;
      if (st_q == LK_IDLE && miss_valid_i) begin
         if (any_hit && head_rdy[hit_id]) begin
            pop[hit_id] = 1'b1;
            touch       = 1'b1;
            touch_id    = hit_id;
            rv_d        = 1'b1;
            rh_d        = 1'b1;
            rd_d        = head_data[hit_id];
         end else if (any_hit) begin
            st_d  = LK_STALL;
            sel_d = hit_id;
         end else begin
            flush[victim] = 1'b1;
            touch         = 1'b1;
            touch_id      = victim;
            rv_d          = 1'b1;
         end
      end else if (st_q == LK_STALL && head_rdy[sel_q]) begin
         pop[sel_q] = 1'b1;
         touch      = 1'b1;
         touch_id   = sel_q;
         rv_d       = 1'b1;
         rh_d       = 1'b1;
         rd_d       = head_data[sel_q];
         st_d       = LK_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= LK_IDLE;
         sel_q        <= '0;
         resp_valid_o <= 1'b0;
         resp_hit_o   <= 1'b0;
         resp_data_o  <= '0;
      end else begin
         st_q         <= st_d;
         sel_q        <= sel_d;
         resp_valid_o <= rv_d;
         resp_hit_o   <= rh_d;
         resp_data_o  <= rd_d;
      end
   end

   assign lookup_busy_o = (st_q == LK_STALL);

   // prefetch issue: one outstanding, demand traffic has priority
   assign pf_req_valid_o = !demand_busy_i && !outst_q && any_iss;
   assign pf_req_addr_o  = next_addr[iss_id];

   always_comb begin
      push = '0;
      if (pf_req_valid_o && pf_req_ack_i) push[iss_id] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q      <= 1'b0;
         outst_id_q   <= '0;
         outst_addr_q <= '0;
      end else if (pf_req_valid_o && pf_req_ack_i) begin
         outst_q      <= 1'b1;
         outst_id_q   <= iss_id;
         outst_addr_q <= pf_req_addr_o;
      end else if (pf_rsp_valid_i) begin
         outst_q      <= 1'b0;
      end
   end
endmodule

// File: rtl/stream_prefetcher_chk.sv
module stream_prefetcher_chk (
   input logic clk,
   input logic rst_n,
   input logic miss_valid_i,
   input logic lookup_busy_o,
   input logic resp_valid_o,
   input logic demand_busy_i,
   input logic pf_req_valid_o,
   input logic pf_req_ack_i,
   input logic pf_rsp_valid_i
);
   AST_DEMAND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      demand_busy_i |-> !pf_req_valid_o); // R4

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_req_valid_o && pf_req_ack_i) |=> !pf_req_valid_o); // R9

   AST_QUIET_UNTIL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!pf_req_valid_o && $past(pf_req_valid_o && pf_req_ack_i) && !pf_rsp_valid_i)
      |=> !pf_req_valid_o); // R9

   AST_MISS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid_i && !lookup_busy_o) |=> (resp_valid_o || lookup_busy_o)); // R2

   AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_busy_o |-> !resp_valid_o); // R6

   AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid_o |-> ($past(miss_valid_i && !lookup_busy_o) || $past(lookup_busy_o))); // R5
endmodule

bind stream_prefetcher stream_prefetcher_chk u_chk (.*);

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid_i = 1'b0;
   logic [AW-1:0] miss_addr_i = '0;
   logic          lookup_busy_o, resp_valid_o, resp_hit_o;
   logic [DW-1:0] resp_data_o;
   logic          demand_busy_i = 1'b0;
   logic          pf_req_valid_o;
   logic [AW-1:0] pf_req_addr_o;
   logic          pf_req_ack_i = 1'b0;
   logic          pf_rsp_valid_i = 1'b0;
   logic [DW-1:0] pf_rsp_data_i = '0;

   stream_prefetcher u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
      return {a ^ 16'hC3C3, a};
   endfunction

   // memory model: acks at the negedge, answers after mem_lat cycles
   logic          mem_hold = 1'b0;
   logic          mem_pend = 1'b0;
   int            mem_lat  = 2;
   int            lat_cnt  = 0;
   logic [AW-1:0] mem_addr = '0;
   logic [AW-1:0] req_log [0:63];
   int            nreq = 0;

   always @(negedge clk) begin
      pf_req_ack_i   = 1'b0;
      pf_rsp_valid_i = 1'b0;
      if (rst_n) begin
         if (mem_pend) begin
            if (lat_cnt > 0) lat_cnt--;
            else if (!mem_hold) begin
               pf_rsp_valid_i = 1'b1;
               pf_rsp_data_i  = mdata(mem_addr);
               mem_pend       = 1'b0;
            end
         end else if (pf_req_valid_o) begin
            pf_req_ack_i = 1'b1;
            mem_addr     = pf_req_addr_o;
            mem_pend     = 1'b1;
            lat_cnt      = mem_lat;
            if (nreq < 64) req_log[nreq] = pf_req_addr_o;
            nreq++;
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic do_miss(input logic [AW-1:0] a, input logic exp_hit, input string req);
      miss_valid_i = 1'b1;
      miss_addr_i  = a;
      tick();
      miss_valid_i = 1'b0;
      check(resp_valid_o == 1'b1, req, 32'(resp_valid_o), 32'd1);
      check(resp_hit_o == exp_hit, req, 32'(resp_hit_o), 32'(exp_hit));
      if (exp_hit) check(resp_data_o == mdata(a), req, resp_data_o, mdata(a));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         summary();
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check(resp_valid_o == 1'b0, "R1", 32'(resp_valid_o), 0);
      check(pf_req_valid_o == 1'b0, "R1", 32'(pf_req_valid_o), 0);
      check(lookup_busy_o == 1'b0, "R1", 32'(lookup_busy_o), 0);
      repeat (5) tick();
      check(nreq == 0, "R1", nreq, 0);

      // R2 + R4: allocate with demand traffic in flight
      demand_busy_i = 1'b1;
      do_miss(16'h0100, 1'b0, "R2");
      begin
         logic seen = 1'b0;
         for (int i = 0; i < 10; i++) begin
            if (pf_req_valid_o) seen = 1'b1;
            tick();
         end
         check(!seen && nreq == 0, "R4", nreq, 0);
      end
      demand_busy_i = 1'b0;
      repeat (60) tick();
      // R3: four sequential requests then stop
      check(nreq == 4, "R3", nreq, 4);
      for (int i = 0; i < 4; i++)
         check(req_log[i] == AW'(16'h0101 + i), "R3", 32'(req_log[i]), 32'(16'h0101 + i));

      // R5 sweep: each head hit refills with the next address
      for (int k = 0; k < 5; k++) begin
         do_miss(AW'(16'h0101 + k), 1'b1, "R5");
         repeat (12) tick();
         check(nreq == 5 + k, "R5", nreq, 5 + k);
         check(req_log[4+k] == AW'(16'h0105 + k), "R5", 32'(req_log[4+k]), 32'(16'h0105 + k));
      end

      // R7: second entry does not match; head survives
      do_miss(16'h0107, 1'b0, "R7");
      repeat (60) tick();
      do_miss(16'h0106, 1'b1, "R7");

      // R8: replacement order
      do_miss(16'h0200, 1'b0, "R8");
      do_miss(16'h0300, 1'b0, "R8");
      do_miss(16'h0500, 1'b0, "R8");
      repeat (100) tick();
      do_miss(16'h0108, 1'b0, "R8");
      repeat (60) tick();
      do_miss(16'h0201, 1'b1, "R8");
      do_miss(16'h0107, 1'b0, "R8");
      repeat (100) tick();

      // R6 + R9: stall on a pending head
      mem_hold = 1'b1;
      do_miss(16'h0700, 1'b0, "R6");
      repeat (3) tick();
      check(pf_req_valid_o == 1'b0, "R9", 32'(pf_req_valid_o), 0);
      miss_valid_i = 1'b1;
      miss_addr_i  = 16'h0701;
      tick();
      miss_valid_i = 1'b0;
      check(lookup_busy_o == 1'b1 && resp_valid_o == 1'b0, "R6", 32'({lookup_busy_o, resp_valid_o}), 32'b10);
      begin
         logic bad = 1'b0;
         for (int i = 0; i < 4; i++) begin
            tick();
            if (!lookup_busy_o || resp_valid_o || pf_req_valid_o) bad = 1'b1;
         end
         check(!bad, "R9", 32'(bad), 0);
      end
      mem_hold = 1'b0;
      tick();
      check(resp_valid_o == 1'b0 && lookup_busy_o == 1'b1, "R6", 32'({lookup_busy_o, resp_valid_o}), 32'b10);
      tick();
      check(resp_valid_o && resp_hit_o && !lookup_busy_o, "R6", 32'({resp_valid_o, resp_hit_o, lookup_busy_o}), 32'b110);
      check(resp_data_o == mdata(16'h0701), "R6", resp_data_o, mdata(16'h0701));
      repeat (60) tick();

      // R10: data for a reallocated stream is dropped
      mem_hold = 1'b1;
      do_miss(16'h0800, 1'b0, "R10");
      repeat (3) tick();
      do_miss(16'h0900, 1'b0, "R10");
      do_miss(16'h0A00, 1'b0, "R10");
      do_miss(16'h0B00, 1'b0, "R10");
      do_miss(16'h0C00, 1'b0, "R10");
      mem_hold = 1'b0;
      repeat (120) tick();
      do_miss(16'h0801, 1'b0, "R10");
      do_miss(16'h0C01, 1'b1, "R10");

      summary();
   end
endmodule